// File: doc/BRIEF.md
# Gated Domain Power Sequencer

This controller sits in an always-on clock domain and takes a gated register domain through a safe shutdown and a safe restart. The gated domain is reached only through register crossings. Each crossing has an allow input, and while allow is low it finishes requests without involving the far side: writes are discarded and reads return the last value seen. Because of this, the requester never needs to be stalled. The sequencer only has to put allow, the power switch enable and the domain reset in the right order, and wait at the right points.

Shutting down takes four steps. Allow drops first. The controller then waits until the crossings report no traffic in flight. Power is then removed, and the domain reset is asserted on the same edge. Starting up takes three steps. Power comes back while reset stays asserted. Reset is released once the switch acknowledges good power and a settle window has elapsed. Allow is raised last, so no crossing ever talks to an unpowered or reset domain. A command for the opposite direction that arrives mid-sequence is held and carried out once the current sequence has reached its end state. A phase output and a one-cycle completion pulse let the surrounding logic follow progress.

Top module: `domain_power_sequencer`

## Requirements
- R1: While reset is asserted and directly after it, the outputs are: phase = 0 (on), allow = 1, power enable = 1, domain reset = 0, done = 0.
- R2: A power-down command seen in phase on drops allow in the next cycle and moves phase to 1 (draining). Power enable stays 1 and domain reset stays 0.
- R3: The busy indicator passes through a two-flop synchroniser. Power is removed only after the synchronised busy has been sampled low on two consecutive edges while draining. If busy is low throughout, phase 2 (off) follows exactly three cycles after draining starts, and any busy high restarts the count.
- R4: Domain reset rises in the same cycle that power enable falls. It stays high throughout phase off and phase 3 (resetting).
- R5: A power-up command seen in phase off raises power enable in the next cycle and moves phase to 3. Domain reset stays high and allow stays low.
- R6: The power-good input passes through a two-flop synchroniser. Domain reset is released, with phase moving to 4 (enabling), once the synchronised power-good has been high for SETTLE_CYCLES consecutive edges while resetting. Allow stays low during phase 4.
- R7: Phase 4 lasts exactly one cycle. After it, allow rises and phase returns to 0. Allow never rises while domain reset is high.
- R8: The done output is high for exactly one cycle: the first cycle of phase off, and the first cycle of phase on after a power-up.
- R9: A power-up command during draining is latched and starts power-up from phase off without a further command. A power-down command during resetting or enabling is latched and starts a new drain from phase on.
- R10: A power-up command in phase on, or a power-down command in phase off, has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rstN | input | 1 | Asynchronous active-low reset |
| downReq | input | 1 | Power-down command, one-cycle pulse |
| upReq | input | 1 | Power-up command, one-cycle pulse |
| busyAsync | input | 1 | Crossing traffic in flight, may be asynchronous |
| pwrGoodAsync | input | 1 | Power switch acknowledge, may be asynchronous |
| gateAllow | output | 1 | Allow to all crossings |
| pwrEnable | output | 1 | Power switch enable for the gated domain |
| domainReset | output | 1 | Active-high reset of the gated domain |
| phase | output | 3 | 0 on, 1 draining, 2 off, 3 resetting, 4 enabling |
| seqDone | output | 1 | One-cycle pulse at sequence completion |

## Verification
The bench builds the block with SETTLE_CYCLES set to 3, not the default 16. This keeps a full off-and-on round trip under about twenty cycles, so a few thousand cycles of random command pulses cover many round trips. They include commands that land in every phase, on the exact edge of a phase change, and while the opposite request is already latched. Busy is driven in short random runs, so a single idle sample inside a drain occurs often and checks that the two-sample confirmation restarts. The bench also models the power switch as a three-cycle delay on power enable, so the power-good synchroniser and the settle counter see real, staggered edges.

// File: rtl/dps_pkg.sv
package dps_pkg;

  typedef enum logic [2:0] {
    PH_ON        = 3'd0,
    PH_DRAIN     = 3'd1,
    PH_OFF       = 3'd2,
    PH_RESETTING = 3'd3,
    PH_ENABLING  = 3'd4
  } phase_e;

  // strobes from the control FSM into the datapath
  typedef struct packed {
    logic holdIdle;    // keep the idle confirmation counter cleared
    logic holdSettle;  // keep the settle counter cleared
    logic takeUp;      // latch a power-up request
    logic takeDown;    // latch a power-down request
    logic dropUp;      // clear the latched power-up request
    logic dropDown;    // clear the latched power-down request
  } dpStrobes_t;

endpackage

// File: rtl/dps_sync.sv
module dps_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= '0;
    else       pipe <= {pipe[STAGES-2:0], din};
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/dps_datapath.sv
module dps_datapath
  import dps_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int IDLE_CONFIRM  = 2,
  parameter int SETTLE_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busyAsync,
  input  logic       pwrGoodAsync,
  input  dpStrobes_t strobes,
  output logic       idleOk,
  output logic       settleDone,
  output logic       pendUp,
  output logic       pendDown
);
  localparam int IW = $clog2(IDLE_CONFIRM + 1);
  localparam int SW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [IW-1:0] IDLE_LAST   = IW'(IDLE_CONFIRM);
  localparam logic [SW-1:0] SETTLE_LAST = SW'(SETTLE_CYCLES);

  logic busySync, goodSync;
  logic [IW-1:0] idleCnt;
  logic [SW-1:0] settleCnt;

  dps_sync #(.STAGES(SYNC_STAGES)) busySyncI (
    .clk(clk), .rstN(rstN), .din(busyAsync), .dout(busySync));
  dps_sync #(.STAGES(SYNC_STAGES)) goodSyncI (
    .clk(clk), .rstN(rstN), .din(pwrGoodAsync), .dout(goodSync));

  // consecutive idle samples while draining
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              idleCnt <= '0;
    else if (strobes.holdIdle || busySync)  idleCnt <= '0;
    else if (idleCnt != IDLE_LAST)          idleCnt <= idleCnt + 1'b1;
  end

  // consecutive power-good samples while resetting
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                 settleCnt <= '0;
    else if (strobes.holdSettle || !goodSync)  settleCnt <= '0;
    else if (settleCnt != SETTLE_LAST)         settleCnt <= settleCnt + 1'b1;
  end

  // opposite-direction requests held until the current sequence ends
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendUp   <= 1'b0;
      pendDown <= 1'b0;
    end else begin
      if (strobes.dropUp)        pendUp   <= 1'b0;
      else if (strobes.takeUp)   pendUp   <= 1'b1;
      if (strobes.dropDown)      pendDown <= 1'b0;
      else if (strobes.takeDown) pendDown <= 1'b1;
    end
  end

  assign idleOk     = (idleCnt == IDLE_LAST);
  assign settleDone = (settleCnt == SETTLE_LAST);

  // R3
  idle_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    idleCnt <= IDLE_LAST);
  // R3
  idle_fresh_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(idleOk) |-> !$past(busySync));
  // R6
  settle_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    settleCnt <= SETTLE_LAST);
  // R6
  settle_good_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(settleDone) |-> $past(goodSync));
endmodule

// File: rtl/dps_control.sv
module dps_control
  import dps_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       upReq,
  input  logic       downReq,
  input  logic       idleOk,
  input  logic       settleDone,
  input  logic       pendUp,
  input  logic       pendDown,
  output dpStrobes_t strobes,
  output logic       gateAllow,
  output logic       pwrEnable,
  output logic       domainReset,
  output logic [2:0] phase,
  output logic       seqDone
);
  phase_e state, nextState;
  logic   finishing;

  always_comb begin
    nextState = state;
    finishing = 1'b0;
    unique case (state)
      PH_ON:        if (downReq || pendDown) nextState = PH_DRAIN;
      PH_DRAIN:     if (idleOk) begin
                      nextState = PH_OFF;
                      finishing = 1'b1;
                    end
      PH_OFF:       if (upReq || pendUp) nextState = PH_RESETTING;
      PH_RESETTING: if (settleDone) nextState = PH_ENABLING;
      PH_ENABLING:  begin
                      nextState = PH_ON;
                      finishing = 1'b1;
                    end
      default:      nextState = PH_ON;
    endcase
  end

  always_comb begin
    strobes.holdIdle   = (state != PH_DRAIN);
    strobes.holdSettle = (state != PH_RESETTING);
    strobes.takeUp     = (state == PH_DRAIN) && upReq;
    strobes.takeDown   = ((state == PH_RESETTING) || (state == PH_ENABLING)) && downReq;
    strobes.dropUp     = (state == PH_OFF);
    strobes.dropDown   = (state == PH_ON);
  end

  // state and outputs registered together: glitch-free power controls
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= PH_ON;
      gateAllow   <= 1'b1;
      pwrEnable   <= 1'b1;
      domainReset <= 1'b0;
      seqDone     <= 1'b0;
    end else begin
      state       <= nextState;
      gateAllow   <= (nextState == PH_ON);
      pwrEnable   <= (nextState != PH_OFF);
      domainReset <= (nextState == PH_OFF) || (nextState == PH_RESETTING);
      seqDone     <= finishing;
    end
  end

  assign phase = state;

  // R2
  drop_allow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_ON && (downReq || pendDown)) |=> (!gateAllow && pwrEnable && !domainReset));
  // R3
  power_off_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pwrEnable) |-> $past(idleOk));
  // R4
  reset_with_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pwrEnable) |-> domainReset);
  // R5
  reset_held_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pwrEnable) |-> (domainReset && !gateAllow));
  // R6
  release_settle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(domainReset) |-> ($past(settleDone) && pwrEnable && !gateAllow));
  // R7
  allow_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateAllow) |-> (pwrEnable && !domainReset && !$past(domainReset)));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |=> !seqDone);
endmodule

// File: rtl/domain_power_sequencer.sv
module domain_power_sequencer
  import dps_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int IDLE_CONFIRM  = 2,
  parameter int SETTLE_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       downReq,
  input  logic       upReq,
  input  logic       busyAsync,
  input  logic       pwrGoodAsync,
  output logic       gateAllow,
  output logic       pwrEnable,
  output logic       domainReset,
  output logic [2:0] phase,
  output logic       seqDone
);
  dpStrobes_t strobes;
  logic idleOk, settleDone, pendUp, pendDown;

  dps_datapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .IDLE_CONFIRM(IDLE_CONFIRM),
    .SETTLE_CYCLES(SETTLE_CYCLES)
  ) dpI (
    .clk(clk), .rstN(rstN),
    .busyAsync(busyAsync), .pwrGoodAsync(pwrGoodAsync),
    .strobes(strobes),
    .idleOk(idleOk), .settleDone(settleDone),
    .pendUp(pendUp), .pendDown(pendDown)
  );

  dps_control ctlI (
    .clk(clk), .rstN(rstN),
    .upReq(upReq), .downReq(downReq),
    .idleOk(idleOk), .settleDone(settleDone),
    .pendUp(pendUp), .pendDown(pendDown),
    .strobes(strobes),
    .gateAllow(gateAllow), .pwrEnable(pwrEnable), .domainReset(domainReset),
    .phase(phase), .seqDone(seqDone)
  );
endmodule

// File: tb/domain_power_sequencer_test.sv
module domain_power_sequencer_test;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 3;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic downReq = 1'b0, upReq = 1'b0, busyAsync = 1'b0, pwrGoodAsync = 1'b1;
  logic gateAllow, pwrEnable, domainReset, seqDone;
  logic [2:0] phase;

  domain_power_sequencer #(.SETTLE_CYCLES(SETTLE)) uut (
    .clk(clk), .rstN(rstN), .downReq(downReq), .upReq(upReq),
    .busyAsync(busyAsync), .pwrGoodAsync(pwrGoodAsync),
    .gateAllow(gateAllow), .pwrEnable(pwrEnable), .domainReset(domainReset),
    .phase(phase), .seqDone(seqDone));

  always #(CLK_PERIOD/2) clk = ~clk;

  int compared = 0, mismatched = 0, cycles = 0;
  bit started = 0, finished = 0;

  // reference model state
  int mPh = 0, mDone = 0, mPendUp = 0, mPendDn = 0;
  int mIdle = 0, mSettle = 0;
  int bS1 = 0, bS2 = 0, gS1 = 0, gS2 = 0;

  always @(posedge clk) begin
    int nPh, nDone;
    started <= 1'b1;
    cycles  <= cycles + 1;
    if (!rstN) begin
      mPh = 0; mDone = 0; mPendUp = 0; mPendDn = 0;
      mIdle = 0; mSettle = 0; bS1 = 0; bS2 = 0; gS1 = 0; gS2 = 0;
    end else begin
      nPh = mPh; nDone = 0;
      case (mPh)
        0: if (downReq || mPendDn != 0) nPh = 1;
        1: if (mIdle == 2) begin nPh = 2; nDone = 1; end
        2: if (upReq || mPendUp != 0) nPh = 3;
        3: if (mSettle == SETTLE) nPh = 4;
        default: begin nPh = 0; nDone = 1; end
      endcase
      if (mPh != 1 || bS2 != 0) mIdle = 0;
      else if (mIdle < 2) mIdle++;
      if (mPh != 3 || gS2 == 0) mSettle = 0;
      else if (mSettle < SETTLE) mSettle++;
      if (mPh == 2) mPendUp = 0;
      else if (mPh == 1 && upReq) mPendUp = 1;
      if (mPh == 0) mPendDn = 0;
      else if ((mPh == 3 || mPh == 4) && downReq) mPendDn = 1;
      bS2 = bS1; bS1 = busyAsync;
      gS2 = gS1; gS1 = pwrGoodAsync;
      mPh = nPh; mDone = nDone;
    end
  end

  task automatic cmp(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cycles, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !finished) begin
      bit inRst = !rstN;
      cmp(inRst ? "R1 phase"  : "R9/R10 phase",    int'(phase),       mPh);
      cmp(inRst ? "R1 allow"  : "R2/R7 allow",     int'(gateAllow),   (mPh == 0) ? 1 : 0);
      cmp(inRst ? "R1 power"  : "R3/R5 power",     int'(pwrEnable),   (mPh != 2) ? 1 : 0);
      cmp(inRst ? "R1 reset"  : "R4/R6 reset",     int'(domainReset), (mPh == 2 || mPh == 3) ? 1 : 0);
      cmp(inRst ? "R1 done"   : "R8 done",         int'(seqDone),     mDone);
    end
  end

  // power switch: acknowledge trails enable by three cycles
  logic [2:0] swDly = 3'b111;
  always @(negedge clk) begin
    swDly        <= {swDly[1:0], pwrEnable};
    pwrGoodAsync <= swDly[2];
  end

  task automatic pulseUp();   @(negedge clk); upReq = 1'b1;   @(negedge clk); upReq = 1'b0;   endtask
  task automatic pulseDown(); @(negedge clk); downReq = 1'b1; @(negedge clk); downReq = 1'b0; endtask
  task automatic idle(int n); repeat (n) @(negedge clk); endtask

  task automatic summary();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);          // R1: reset state observed
    rstN = 1'b1;
    idle(3);
    pulseUp();                           // R10: ignored while on
    idle(4);
    busyAsync = 1'b1;
    pulseDown();                         // R2: allow drops, drain waits
    idle(4);
    busyAsync = 1'b0; idle(1);
    busyAsync = 1'b1; idle(2);           // R3: single idle sample restarts count
    busyAsync = 1'b0;
    idle(8);
    pulseDown();                         // R10: ignored while off
    idle(3);
    pulseUp();                           // R5, R6, R7, R8: full power-up
    idle(20);
    pulseDown();
    pulseUp();                           // R9: latched during drain
    idle(25);
    pulseDown();                         // R2 again, then off
    idle(8);
    pulseUp();
    idle(2);
    pulseDown();                         // R9: latched during resetting
    idle(30);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      upReq     = ($urandom_range(0, 15) == 0);
      downReq   = ($urandom_range(0, 15) == 0);
      if ($urandom_range(0, 3) == 0) busyAsync = $urandom_range(0, 1) != 0;
    end
    @(negedge clk); upReq = 1'b0; downReq = 1'b0; busyAsync = 1'b0;
    idle(30);
    summary();
  end

  initial begin
    wait (cycles > WATCHDOG);
    @(negedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog: actual %0d cycles expected under %0d", cycles, WATCHDOG);
    summary();
  end
endmodule